// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block collects interrupt causes into set/clear register pairs and reduces them to one interrupt line. It holds a 32-bit main event register with a 32-bit mask, an 8-context transmit event/mask pair and a 4-context receive event/mask pair. Hardware pulses set event bits. Software sets and clears bits by writing ones to a set address or to a clear address of the register it targets.

Two bits of the main event register are not storage. Bit 6 shows, live, whether any transmit context has an enabled event. Bit 7 does the same for the receive contexts. Reading a clear address of an event register returns its masked view, so software can see the pending causes in one read. The interrupt output is the masked OR of the main register, gated by a master-enable bit in the main mask.

The address is four bits. Bits 3:1 select the register: 0 is the main event, 1 the main mask, 2 the transmit event, 3 the transmit mask, 4 the receive event and 5 the receive mask. Bit 0 selects the set port (0) or the clear port (1). Reads are combinational on `rd_addr`. Writes take effect at the clock edge where `wr_en` is high.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset every event and mask register reads zero at both of its addresses and `irq` is low.
- R2: A write to a set address sets each register bit whose data bit is 1 at the next clock edge. Bits whose data bit is 0 are unchanged.
- R3: A write to a clear address clears each register bit whose data bit is 1 at the next clock edge. Bits whose data bit is 0 are unchanged.
- R4: A hardware event pulse sets its event bit at the next edge. If a software clear of the same bit falls in the same cycle, the bit still ends up set.
- R5: Reading an event register at its set address (bit 0 = 0) returns the raw event value. Reading it at its clear address (bit 0 = 1) returns event AND mask. A mask register reads the same at both addresses.
- R6: The transmit pair holds 8 bits and the receive pair holds 4 bits. Higher data bits written to them are dropped, and those bits read as zero.
- R7: Main event bit 6 always equals the OR over the 8 transmit contexts of event AND mask. Main event bit 7 always equals the OR over the 4 receive contexts of event AND mask. Both follow the context registers in the same cycle, with no latching.
- R8: Software writes and hardware pulses aimed at main event bits 6 and 7 have no effect on those bits.
- R9: `irq` is high exactly when main mask bit 31 is 1 and at least one bit in 30:0 of (main event view AND main mask) is 1.
- R10: A pulse on `hw_cyc_overrun` sets main event bit 25. A pulse on `hw_phy_rcvd` sets main event bit 26.
- R11: Register IDs 6 and 7 (addresses 12 to 15) read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address: register ID in 3:1, clear select in 0 |
| wr_data | input | 32 | Write data; each 1 sets or clears the bit in that position |
| rd_addr | input | 4 | Read address, same encoding as the write address |
| rd_data | output | 32 | Combinational read data |
| hw_main_evt | input | 32 | Hardware event pulses for the main register |
| hw_cyc_overrun | input | 1 | Cycle-overrun event pulse, sets bit 25 |
| hw_phy_rcvd | input | 1 | PHY register received pulse, sets bit 26 |
| hw_tx_evt | input | 8 | Transmit context event pulses |
| hw_rx_evt | input | 4 | Receive context event pulses |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a hardware pulse and a software clear landing on the same bit in the same cycle. The stimulus reaches it by driving both in one cycle through a single combined task, for a main bit and for a transmit context. The second is a summary bit dropping without any write to the main register. The sweeps reach it by stepping every context through every mask setting and then clearing the context event only, while checking bit 6 or 7 and `irq` at each step.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [2:0] {
        RID_MAIN_EVT = 3'd0,
        RID_MAIN_MSK = 3'd1,
        RID_TX_EVT   = 3'd2,
        RID_TX_MSK   = 3'd3,
        RID_RX_EVT   = 3'd4,
        RID_RX_MSK   = 3'd5,
        RID_SPARE6   = 3'd6,
        RID_SPARE7   = 3'd7
    } reg_id_e;

    typedef struct packed {
        logic evt_set;
        logic evt_clr;
        logic msk_set;
        logic msk_clr;
    } pair_we_t;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
    import irq_agg_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output pair_we_t          main_we,
    output pair_we_t          tx_we,
    output pair_we_t          rx_we
);

    reg_id_e rid;
    logic    is_clr;

    assign rid    = reg_id_e'(wr_addr[3:1]);
    assign is_clr = wr_addr[0];

    always_comb begin
        main_we = '0;
        tx_we   = '0;
        rx_we   = '0;
        if (wr_en) begin
            unique case (rid)
                RID_MAIN_EVT: begin main_we.evt_set = !is_clr; main_we.evt_clr = is_clr; end
                RID_MAIN_MSK: begin main_we.msk_set = !is_clr; main_we.msk_clr = is_clr; end
                RID_TX_EVT:   begin tx_we.evt_set   = !is_clr; tx_we.evt_clr   = is_clr; end
                RID_TX_MSK:   begin tx_we.msk_set   = !is_clr; tx_we.msk_clr   = is_clr; end
                RID_RX_EVT:   begin rx_we.evt_set   = !is_clr; rx_we.evt_clr   = is_clr; end
                RID_RX_MSK:   begin rx_we.msk_set   = !is_clr; rx_we.msk_clr   = is_clr; end
                RID_SPARE6, RID_SPARE7: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/evt_mask_pair.sv
module evt_mask_pair
    import irq_agg_pkg::*;
#(
    parameter int         W    = 8,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pair_we_t     we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] evt_q,
    output logic [W-1:0] msk_q
);

    logic [W-1:0] evt_d;
    logic [W-1:0] msk_d;

    // Software clear, then software set, then hardware set: hardware wins.
    always_comb begin
        evt_d = evt_q;
        if (we.evt_clr) evt_d = evt_d & ~wdata;
        if (we.evt_set) evt_d = evt_d | wdata;
        evt_d = (evt_d | hw_set) & KEEP;

        msk_d = msk_q;
        if (we.msk_clr) msk_d = msk_d & ~wdata;
        if (we.msk_set) msk_d = msk_d | wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
            msk_q <= '0;
        end else begin
            evt_q <= evt_d;
            msk_q <= msk_d;
        end
    end

    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we.msk_set |=> ((msk_q & $past(wdata)) == $past(wdata)));

    p_evt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we.evt_clr |=> ((evt_q & $past(wdata & ~hw_set)) == '0));

    p_hw_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_set & KEEP)) |=> ((evt_q & $past(hw_set & KEEP)) == $past(hw_set & KEEP)));

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TX_N   = 8,
    parameter int RX_N   = 4
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] main_view,
    input  logic [DATA_W-1:0] main_msk,
    input  logic [TX_N-1:0]   tx_evt,
    input  logic [TX_N-1:0]   tx_msk,
    input  logic [RX_N-1:0]   rx_evt,
    input  logic [RX_N-1:0]   rx_msk,
    output logic [DATA_W-1:0] rd_data
);

    localparam int TX_PAD = DATA_W - TX_N;
    localparam int RX_PAD = DATA_W - RX_N;

    reg_id_e rid;
    logic    masked;

    assign rid    = reg_id_e'(rd_addr[3:1]);
    assign masked = rd_addr[0];

    always_comb begin
        rd_data = '0;
        unique case (rid)
            RID_MAIN_EVT: rd_data = masked ? (main_view & main_msk) : main_view;
            RID_MAIN_MSK: rd_data = main_msk;
            RID_TX_EVT:   rd_data = {{TX_PAD{1'b0}}, (masked ? (tx_evt & tx_msk) : tx_evt)};
            RID_TX_MSK:   rd_data = {{TX_PAD{1'b0}}, tx_msk};
            RID_RX_EVT:   rd_data = {{RX_PAD{1'b0}}, (masked ? (rx_evt & rx_msk) : rx_evt)};
            RID_RX_MSK:   rd_data = {{RX_PAD{1'b0}}, rx_msk};
            RID_SPARE6, RID_SPARE7: rd_data = '0;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
    import irq_agg_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int TX_N       = 8,
    parameter int RX_N       = 4,
    parameter int TX_SUM_BIT = 6,
    parameter int RX_SUM_BIT = 7,
    parameter int CYC_BIT    = 25,
    parameter int PHY_BIT    = 26,
    parameter int MASTER_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] hw_main_evt,
    input  logic              hw_cyc_overrun,
    input  logic              hw_phy_rcvd,
    input  logic [TX_N-1:0]   hw_tx_evt,
    input  logic [RX_N-1:0]   hw_rx_evt,
    output logic              irq
);

    localparam logic [DATA_W-1:0] SUM_BITS  = (DATA_W'(1) << TX_SUM_BIT) | (DATA_W'(1) << RX_SUM_BIT);
    localparam logic [DATA_W-1:0] MAIN_KEEP = ~SUM_BITS;
    localparam logic [DATA_W-1:0] IRQ_SPAN  = ~(DATA_W'(1) << MASTER_BIT);

    pair_we_t          main_we, tx_we, rx_we;
    logic [DATA_W-1:0] main_evt_q, main_msk_q, main_view, main_hw;
    logic [TX_N-1:0]   tx_evt_q, tx_msk_q;
    logic [RX_N-1:0]   rx_evt_q, rx_msk_q;
    logic              tx_sum, rx_sum;

    irq_addr_dec u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .main_we (main_we),
        .tx_we   (tx_we),
        .rx_we   (rx_we)
    );

    always_comb begin
        main_hw          = hw_main_evt;
        main_hw[CYC_BIT] = hw_main_evt[CYC_BIT] | hw_cyc_overrun;
        main_hw[PHY_BIT] = hw_main_evt[PHY_BIT] | hw_phy_rcvd;
    end

    evt_mask_pair #(.W(DATA_W), .KEEP(MAIN_KEEP)) u_main (
        .clk (clk), .rst_n (rst_n), .we (main_we), .wdata (wr_data),
        .hw_set (main_hw), .evt_q (main_evt_q), .msk_q (main_msk_q)
    );

    evt_mask_pair #(.W(TX_N), .KEEP({TX_N{1'b1}})) u_tx (
        .clk (clk), .rst_n (rst_n), .we (tx_we), .wdata (wr_data[TX_N-1:0]),
        .hw_set (hw_tx_evt), .evt_q (tx_evt_q), .msk_q (tx_msk_q)
    );

    evt_mask_pair #(.W(RX_N), .KEEP({RX_N{1'b1}})) u_rx (
        .clk (clk), .rst_n (rst_n), .we (rx_we), .wdata (wr_data[RX_N-1:0]),
        .hw_set (hw_rx_evt), .evt_q (rx_evt_q), .msk_q (rx_msk_q)
    );

    assign tx_sum = |(tx_evt_q & tx_msk_q);
    assign rx_sum = |(rx_evt_q & rx_msk_q);

    always_comb begin
        main_view             = main_evt_q;
        main_view[TX_SUM_BIT] = tx_sum;
        main_view[RX_SUM_BIT] = rx_sum;
    end

    assign irq = main_msk_q[MASTER_BIT] & (|(main_view & main_msk_q & IRQ_SPAN));

    irq_rd_mux #(.DATA_W(DATA_W), .TX_N(TX_N), .RX_N(RX_N)) u_rd (
        .rd_addr   (rd_addr),
        .main_view (main_view),
        .main_msk  (main_msk_q),
        .tx_evt    (tx_evt_q),
        .tx_msk    (tx_msk_q),
        .rx_evt    (rx_evt_q),
        .rx_msk    (rx_msk_q),
        .rd_data   (rd_data)
    );

    p_master_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !main_msk_q[MASTER_BIT] |-> !irq);

    p_masked_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 4'd1) |-> ((rd_data & ~main_msk_q) == '0));

    p_tx_summary_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 4'd0) |-> (rd_data[TX_SUM_BIT] == |(tx_evt_q & tx_msk_q)));

    p_rx_summary_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 4'd0) |-> (rd_data[RX_SUM_BIT] == |(rx_evt_q & rx_msk_q)));

    p_cyc_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_cyc_overrun |=> main_evt_q[CYC_BIT]);

endmodule

// File: tb/evt_irq_agg_test.sv
module evt_irq_agg_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic [31:0] hw_main_evt;
    logic        hw_cyc_overrun;
    logic        hw_phy_rcvd;
    logic [7:0]  hw_tx_evt;
    logic [3:0]  hw_rx_evt;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    logic [31:0] me, mm;
    logic [7:0]  te, tm;
    logic [3:0]  re, rm;

    localparam logic [31:0] KEEP = 32'hFFFF_FF3F;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_agg uut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
        .hw_main_evt (hw_main_evt), .hw_cyc_overrun (hw_cyc_overrun),
        .hw_phy_rcvd (hw_phy_rcvd), .hw_tx_evt (hw_tx_evt),
        .hw_rx_evt (hw_rx_evt), .irq (irq)
    );

    function automatic logic [31:0] view();
        logic [31:0] v = me;
        v[6] = |(te & tm);
        v[7] = |(re & rm);
        return v;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        logic [31:0] v = view();
        case (a[3:1])
            3'd0: return a[0] ? (v & mm) : v;
            3'd1: return mm;
            3'd2: return {24'd0, a[0] ? (te & tm) : te};
            3'd3: return {24'd0, tm};
            3'd4: return {28'd0, a[0] ? (re & rm) : re};
            3'd5: return {28'd0, rm};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_irq();
        logic [31:0] v = view() & mm;
        return mm[31] & (|v[30:0]);
    endfunction

    // One clock cycle of stimulus, then the model is updated in hardware order.
    task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d,
                       input logic [31:0] hm, input logic co, input logic pr,
                       input logic [7:0] ht, input logic [3:0] hr);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        hw_main_evt = hm; hw_cyc_overrun = co; hw_phy_rcvd = pr;
        hw_tx_evt = ht; hw_rx_evt = hr;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; hw_main_evt = '0;
        hw_cyc_overrun = 1'b0; hw_phy_rcvd = 1'b0; hw_tx_evt = '0; hw_rx_evt = '0;
        if (we) begin
            case (a)
                4'd0: me = me | d;
                4'd1: me = me & ~d;
                4'd2: mm = mm | d;
                4'd3: mm = mm & ~d;
                4'd4: te = te | d[7:0];
                4'd5: te = te & ~d[7:0];
                4'd6: tm = tm | d[7:0];
                4'd7: tm = tm & ~d[7:0];
                4'd8: re = re | d[3:0];
                4'd9: re = re & ~d[3:0];
                4'd10: rm = rm | d[3:0];
                4'd11: rm = rm & ~d[3:0];
                default: ;
            endcase
        end
        me = me | hm;
        if (co) me[25] = 1'b1;
        if (pr) me[26] = 1'b1;
        me = me & KEEP;
        te = te | ht;
        re = re | hr;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, '0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 16; a++) begin
            rd_addr = a[3:0];
            #1;
            checks++;
            if (rd_data !== exp_rd(a[3:0])) begin
                fails++;
                $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data, exp_rd(a[3:0]));
            end
        end
        checks++;
        if (irq !== exp_irq()) begin
            fails++;
            $display("FAIL %s irq actual %b expected %b", tag, irq, exp_irq());
        end
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        hw_main_evt = '0; hw_cyc_overrun = 1'b0; hw_phy_rcvd = 1'b0;
        hw_tx_evt = '0; hw_rx_evt = '0;
        me = '0; mm = '0; te = '0; tm = '0; re = '0; rm = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2/R3/R5: walking one through every register, set then clear
        for (int r = 0; r < 6; r++) begin
            for (int b = 0; b < 32; b++) begin
                wr(4'(2*r), 32'd1 << b);
                check_all("R2 R5 walk set");
                wr(4'(2*r + 1), 32'd1 << b);
                check_all("R3 walk clear");
            end
        end

        // R2/R3: zeros leave bits alone
        wr(4'd2, 32'hA5A5_0F0F);
        wr(4'd2, 32'h0000_0000);
        wr(4'd3, 32'h0000_0001);
        check_all("R2 R3 zeros unaffected");
        wr(4'd3, 32'hFFFF_FFFF);

        // R7/R9/R5: every tx context over mask on/off, main mask all ones
        wr(4'd2, 32'hFFFF_FFFF);
        for (int c = 0; c < 8; c++) begin
            for (int m = 0; m < 2; m++) begin
                if (m == 1) wr(4'd6, 32'd1 << c);
                cyc(1'b0, 4'd0, '0, '0, 1'b0, 1'b0, 8'd1 << c, '0);
                check_all("R7 R9 tx summary set");
                wr(4'd5, 32'd1 << c);
                check_all("R7 tx summary drops");
                wr(4'd7, 32'hFF);
            end
        end
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 2; m++) begin
                if (m == 1) wr(4'd10, 32'd1 << c);
                cyc(1'b0, 4'd0, '0, '0, 1'b0, 1'b0, '0, 4'd1 << c);
                check_all("R7 R9 rx summary set");
                wr(4'd9, 32'd1 << c);
                check_all("R7 rx summary drops");
                wr(4'd11, 32'hF);
            end
        end

        // R6: upper bits of narrow pairs dropped
        wr(4'd4, 32'hFFFF_FFFF); wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF); wr(4'd10, 32'hFFFF_FFFF);
        check_all("R6 narrow widths");
        wr(4'd5, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd9, 32'hFFFF_FFFF); wr(4'd11, 32'hFFFF_FFFF);
        check_all("R6 narrow cleared");

        // R8: summary bits not writable, not settable by hardware
        wr(4'd0, 32'h0000_00C0);
        check_all("R8 sw set of summary bits");
        cyc(1'b0, 4'd0, '0, 32'h0000_00C0, 1'b0, 1'b0, '0, '0);
        check_all("R8 hw set of summary bits");

        // R4: hardware pulse wins over same-cycle clear
        wr(4'd0, 32'h0000_0008);
        cyc(1'b1, 4'd1, 32'h0000_0008, 32'h0000_0008, 1'b0, 1'b0, '0, '0);
        check_all("R4 main hw beats clear");
        wr(4'd6, 32'h10);
        cyc(1'b1, 4'd5, 32'h10, '0, 1'b0, 1'b0, 8'h10, '0);
        check_all("R4 tx hw beats clear");
        wr(4'd5, 32'hFF); wr(4'd1, 32'hFFFF_FFFF);

        // R10: dedicated cause inputs
        cyc(1'b0, 4'd0, '0, '0, 1'b1, 1'b0, '0, '0);
        check_all("R10 cycle overrun bit 25");
        cyc(1'b0, 4'd0, '0, '0, 1'b0, 1'b1, '0, '0);
        check_all("R10 phy received bit 26");
        wr(4'd1, 32'hFFFF_FFFF);

        // R11: spare IDs
        for (int a = 12; a < 16; a++) begin
            wr(4'(a), 32'hFFFF_FFFF);
            check_all("R11 spare address");
        end

        // R9: master gate over each plain bit
        for (int b = 0; b < 31; b++) begin
            if (b == 6 || b == 7) continue;
            wr(4'd0, 32'd1 << b);
            wr(4'd3, 32'h8000_0000);
            check_all("R9 master off");
            wr(4'd2, 32'h8000_0000);
            check_all("R9 master on");
            wr(4'd1, 32'd1 << b);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule